// File: doc/BRIEF.md
# Frame Sync Waveform Generator

This block produces the frame synchronisation line of a synchronous serial port, for either the transmit or the receive side. A bit-rate enable paces it, and a start strobe from an outside start detector launches it. Each frame may begin with a sync slot, a pulse of programmable width. A data phase follows, and its length is the word size times the number of words. During the data phase the block gives the shifter the index of the bit now on the wire, in either bit order.

The line can be left undriven, driven as a negative or positive pulse, held low or high for the length of the data phase, or flipped at every frame start. If sync data is enabled, the block serves the pulse slot as an extra data field. It supplies outgoing bits from a sync word and captures incoming bits into a capture register. A separate detector watches the sampled sync pin and reports one selected edge. All configuration inputs must stay stable while a frame is in progress.

Top module: `frame_sync_gen`

## Requirements
- R1: After reset the block is idle: `active` = 0, `bit_idx` = 0, `sync_slot` = 0, `sync_cap` = 0, `sync_seen` = 0, and the internal toggle level is 0.
- R2: When `mode` is 0, 6 or 7, `sync_oe` = 0 and `sync_out` = 0 at all times. Frames still run, and `active` and `bit_idx` behave as in the other modes.
- R3: `mode` 1 gives a negative pulse and `mode` 2 a positive pulse, with `sync_oe` = 1 in both. The pulse starts in the cycle after the start is accepted and lasts `sync_len`+1 bit ticks. Outside the pulse the line rests at the opposite level.
- R4: `mode` 3 drives the line low and `mode` 4 drives it high for exactly the cycles in which `active` = 1. At all other times the line rests at the opposite level, with `sync_oe` = 1.
- R5: `mode` 5 drives the toggle level with `sync_oe` = 1. The toggle level inverts at every accepted frame start and at no other time.
- R6: A start is accepted on a cycle with `bit_en` = 1 and `frame_start` = 1. `active` is then high for (`word_len`+1)×(`word_cnt`+1) bit ticks. In modes 1 and 2 these ticks come straight after the sync slot; in all other modes they begin in the cycle after acceptance.
- R7: While `active` = 1, `bit_idx` counts 0 up to `word_len` within each word when `msb_first` = 0, and counts `word_len` down to 0 when `msb_first` = 1.
- R8: A `frame_start` that arrives during a sync slot, or during any data tick except the last, is ignored. The frame length and the toggle level are unchanged.
- R9: A start that arrives on the last data tick begins the next frame at once, with no idle cycle between the two frames.
- R10: When `sync_data_en` = 1 in modes 1 and 2, `sync_slot` is 1 throughout the pulse. In slot tick i (counting from 0), `sync_tx_bit` carries `sync_word` bit i when `msb_first` = 0, or bit `sync_len`−i when `msb_first` = 1. Outside the slot both outputs are 0.
- R11: In slot tick i, `ser_in` is stored into `sync_cap` at the same bit position that R10 uses. `sync_cap` is cleared when a start is accepted and otherwise keeps its value.
- R12: On each bit tick the block samples `sync_pin_in`. When `edge_sel` = 0 a 0→1 change is reported, and when `edge_sel` = 1 a 1→0 change is reported. The report is a one-cycle pulse on `sync_seen` in the cycle after the tick. The first sample is compared against a low level.
- R13: While `bit_en` = 0, no counter or phase advances and no start is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_en | input | 1 | Bit-rate enable, one tick per serial bit |
| frame_start | input | 1 | Start strobe from the start detector |
| mode | input | 3 | Line shape select |
| sync_len | input | 4 | Sync pulse width minus one, in bit ticks |
| word_len | input | 5 | Word size minus one |
| word_cnt | input | 4 | Words per frame minus one |
| msb_first | input | 1 | Bit order select |
| sync_data_en | input | 1 | Treat the sync slot as a data field |
| edge_sel | input | 1 | Detected edge: 0 rising, 1 falling |
| sync_word | input | 16 | Bits sent in the sync slot |
| ser_in | input | 1 | Serial data sampled during the sync slot |
| sync_pin_in | input | 1 | Sampled level of the sync pin |
| sync_out | output | 1 | Sync line value |
| sync_oe | output | 1 | Sync line output enable |
| active | output | 1 | Data phase in progress |
| bit_idx | output | 5 | Index of the current data bit |
| sync_slot | output | 1 | Sync slot carries data |
| sync_tx_bit | output | 1 | Sync word bit for the current slot tick |
| sync_cap | output | 16 | Bits captured in the last sync slot |
| sync_seen | output | 1 | Selected edge seen on the sync pin |

## Verification
A fault in the phase sequencer shows up at the ports within one cycle, as a wrong pulse width, a wrong `active` window or a wrong `bit_idx` order. The bench therefore compares every cycle of whole frames in every line mode. A toggle level that drifts, or a start that is wrongly accepted in mid-frame, stays hidden until the line or the frame end is compared. For that reason the checks continue past the end of the frame. Faults in slot data and in edge reporting appear in the slot cycle itself or one cycle after the sampled change.

// File: rtl/fsg_pkg.sv
package fsg_pkg;
   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_SYNC = 2'd1,
      PH_DATA = 2'd2
   } fsg_phase_t;

   localparam logic [2:0] LM_OFF    = 3'd0;
   localparam logic [2:0] LM_NEG    = 3'd1;
   localparam logic [2:0] LM_POS    = 3'd2;
   localparam logic [2:0] LM_LOW    = 3'd3;
   localparam logic [2:0] LM_HIGH   = 3'd4;
   localparam logic [2:0] LM_TOGGLE = 3'd5;

   function automatic logic is_pulse_mode(input logic [2:0] m);
      return (m == LM_NEG) || (m == LM_POS);
   endfunction
endpackage

// File: rtl/fsg_seq.sv
module fsg_seq
   import fsg_pkg::*;
#(
   parameter int LEN_W  = 5,
   parameter int CNT_W  = 4,
   parameter int SLEN_W = 4
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_en,
   input  logic              frame_start,
   input  logic [2:0]        mode,
   input  logic [SLEN_W-1:0] sync_len,
   input  logic [LEN_W-1:0]  word_len,
   input  logic [CNT_W-1:0]  word_cnt,
   output fsg_phase_t        phase,
   output logic              start_acc,
   output logic [SLEN_W-1:0] slot_left,
   output logic [LEN_W-1:0]  bit_pos
);
   fsg_phase_t        ph_q;
   logic [SLEN_W-1:0] cnt_q;
   logic [LEN_W-1:0]  bit_q;
   logic [CNT_W-1:0]  word_q;
   logic              last_tick;

   assign last_tick = (ph_q == PH_DATA) && (bit_q == word_len) && (word_q == word_cnt);
   assign start_acc = bit_en && frame_start && ((ph_q == PH_IDLE) || last_tick);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q   <= PH_IDLE;
         cnt_q  <= '0;
         bit_q  <= '0;
         word_q <= '0;
      end else if (bit_en) begin
         if (start_acc) begin
            bit_q  <= '0;
            word_q <= '0;
            if (is_pulse_mode(mode)) begin
               ph_q  <= PH_SYNC;
               cnt_q <= sync_len;
            end else begin
               ph_q  <= PH_DATA;
               cnt_q <= '0;
            end
         end else begin
            unique case (ph_q)
               PH_SYNC: begin
                  if (cnt_q == '0) begin
                     ph_q   <= PH_DATA;
                     bit_q  <= '0;
                     word_q <= '0;
                  end else begin
                     cnt_q <= cnt_q - 1'b1;
                  end
               end
               PH_DATA: begin
                  if (bit_q == word_len) begin
                     bit_q <= '0;
                     if (word_q == word_cnt) ph_q <= PH_IDLE;
                     else                    word_q <= word_q + 1'b1;
                  end else begin
                     bit_q <= bit_q + 1'b1;
                  end
               end
               default: ph_q <= PH_IDLE;
            endcase
         end
      end
   end

   assign phase     = ph_q;
   assign slot_left = cnt_q;
   assign bit_pos   = bit_q;

   a_r13_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
      !bit_en |=> $stable(ph_q) && $stable(bit_q) && $stable(cnt_q) && $stable(word_q));

   a_r6_bit_in_word: assert property (@(posedge clk) disable iff (!rst_n)
      (ph_q == PH_DATA) |-> (bit_q <= word_len));

   a_r8_no_restart_midframe: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_en && ph_q == PH_DATA && !last_tick && !(bit_q == word_len && word_q == word_cnt))
      |=> (ph_q == PH_DATA));
endmodule

// File: rtl/fsg_wave.sv
module fsg_wave
   import fsg_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic [2:0] mode,
   input  fsg_phase_t phase,
   input  logic       start_acc,
   output logic       sync_out,
   output logic       sync_oe
);
   logic tog_q;
   logic in_slot;
   logic in_data;

   assign in_slot = (phase == PH_SYNC);
   assign in_data = (phase == PH_DATA);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         tog_q <= 1'b0;
      else if (start_acc) tog_q <= ~tog_q;
   end

   always_comb begin
      sync_oe  = 1'b1;
      sync_out = 1'b0;
      case (mode)
         LM_NEG:    sync_out = ~in_slot;
         LM_POS:    sync_out = in_slot;
         LM_LOW:    sync_out = ~in_data;
         LM_HIGH:   sync_out = in_data;
         LM_TOGGLE: sync_out = tog_q;
         default: begin
            sync_oe  = 1'b0;
            sync_out = 1'b0;
         end
      endcase
   end

   a_r5_toggle_only_on_start: assert property (@(posedge clk) disable iff (!rst_n)
      !start_acc |=> $stable(tog_q));
endmodule

// File: rtl/fsg_slotdata.sv
module fsg_slotdata
   import fsg_pkg::*;
#(
   parameter int SLEN_W     = 4,
   parameter bit CAPTURE_EN = 1'b1,
   localparam int SYNC_W    = 1 << SLEN_W
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_en,
   input  logic              start_acc,
   input  fsg_phase_t        phase,
   input  logic              data_en,
   input  logic              msb_first,
   input  logic [SLEN_W-1:0] sync_len,
   input  logic [SLEN_W-1:0] slot_left,
   input  logic [SYNC_W-1:0] sync_word,
   input  logic              ser_in,
   output logic              slot,
   output logic              tx_bit,
   output logic [SYNC_W-1:0] cap
);
   logic [SLEN_W-1:0] pos;

   assign slot   = data_en && (phase == PH_SYNC);
   assign pos    = msb_first ? slot_left : (sync_len - slot_left);
   assign tx_bit = slot ? sync_word[pos] : 1'b0;

   generate
      if (CAPTURE_EN) begin : g_cap
         logic [SYNC_W-1:0] cap_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                cap_q <= '0;
            else if (start_acc)        cap_q <= '0;
            else if (bit_en && slot)   cap_q[pos] <= ser_in;
         end
         assign cap = cap_q;

         a_r11_cap_quiet_outside_slot: assert property (@(posedge clk) disable iff (!rst_n)
            (!slot && !start_acc) |=> $stable(cap_q));
      end else begin : g_nocap
         assign cap = '0;
      end
   endgenerate
endmodule

// File: rtl/fsg_edge.sv
module fsg_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic bit_en,
   input  logic edge_sel,
   input  logic pin,
   output logic seen
);
   logic prev_q;
   logic seen_q;
   logic hit;

   assign hit = edge_sel ? (prev_q & ~pin) : (~prev_q & pin);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= 1'b0;
         seen_q <= 1'b0;
      end else begin
         seen_q <= bit_en & hit;
         if (bit_en) prev_q <= pin;
      end
   end

   assign seen = seen_q;

   a_r12_no_double_report: assert property (@(posedge clk) disable iff (!rst_n)
      seen_q |=> !seen_q);
endmodule

// File: rtl/frame_sync_gen.sv
module frame_sync_gen
   import fsg_pkg::*;
#(
   parameter int LEN_W      = 5,
   parameter int CNT_W      = 4,
   parameter int SLEN_W     = 4,
   parameter bit CAPTURE_EN = 1'b1,
   localparam int SYNC_W    = 1 << SLEN_W
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_en,
   input  logic              frame_start,
   input  logic [2:0]        mode,
   input  logic [SLEN_W-1:0] sync_len,
   input  logic [LEN_W-1:0]  word_len,
   input  logic [CNT_W-1:0]  word_cnt,
   input  logic              msb_first,
   input  logic              sync_data_en,
   input  logic              edge_sel,
   input  logic [SYNC_W-1:0] sync_word,
   input  logic              ser_in,
   input  logic              sync_pin_in,
   output logic              sync_out,
   output logic              sync_oe,
   output logic              active,
   output logic [LEN_W-1:0]  bit_idx,
   output logic              sync_slot,
   output logic              sync_tx_bit,
   output logic [SYNC_W-1:0] sync_cap,
   output logic              sync_seen
);
   generate
      if (LEN_W < 1 || LEN_W > 8)   begin : g_bad_len  $error("LEN_W out of range");  end
      if (CNT_W < 1 || CNT_W > 8)   begin : g_bad_cnt  $error("CNT_W out of range");  end
      if (SLEN_W < 1 || SLEN_W > 6) begin : g_bad_slen $error("SLEN_W out of range"); end
   endgenerate

   fsg_phase_t        phase;
   logic              start_acc;
   logic [SLEN_W-1:0] slot_left;
   logic [LEN_W-1:0]  bit_pos;

   fsg_seq #(.LEN_W(LEN_W), .CNT_W(CNT_W), .SLEN_W(SLEN_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .frame_start(frame_start),
      .mode(mode), .sync_len(sync_len), .word_len(word_len), .word_cnt(word_cnt),
      .phase(phase), .start_acc(start_acc), .slot_left(slot_left), .bit_pos(bit_pos)
   );

   fsg_wave u_wave (
      .clk(clk), .rst_n(rst_n), .mode(mode), .phase(phase), .start_acc(start_acc),
      .sync_out(sync_out), .sync_oe(sync_oe)
   );

   fsg_slotdata #(.SLEN_W(SLEN_W), .CAPTURE_EN(CAPTURE_EN)) u_slot (
      .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .start_acc(start_acc), .phase(phase),
      .data_en(sync_data_en), .msb_first(msb_first), .sync_len(sync_len),
      .slot_left(slot_left), .sync_word(sync_word), .ser_in(ser_in),
      .slot(sync_slot), .tx_bit(sync_tx_bit), .cap(sync_cap)
   );

   fsg_edge u_edge (
      .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .edge_sel(edge_sel),
      .pin(sync_pin_in), .seen(sync_seen)
   );

   assign active  = (phase == PH_DATA);
   assign bit_idx = !active ? '0 : (msb_first ? (word_len - bit_pos) : bit_pos);

   a_r7_index_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      active |-> (bit_idx <= word_len));

   a_r2_silent_modes: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 3'd0 || mode == 3'd6 || mode == 3'd7) |-> (!sync_oe && !sync_out));
endmodule

// File: tb/sim_frame_sync_gen.sv
module sim_frame_sync_gen;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bit_en = 1'b1;
   logic        frame_start = 1'b0;
   logic [2:0]  mode = 3'd0;
   logic [3:0]  sync_len = 4'd0;
   logic [4:0]  word_len = 5'd0;
   logic [3:0]  word_cnt = 4'd0;
   logic        msb_first = 1'b0;
   logic        sync_data_en = 1'b0;
   logic        edge_sel = 1'b0;
   logic [15:0] sync_word = 16'h0;
   logic        ser_in = 1'b0;
   logic        sync_pin_in = 1'b0;
   logic        sync_out, sync_oe, active, sync_slot, sync_tx_bit, sync_seen;
   logic [4:0]  bit_idx;
   logic [15:0] sync_cap;

   int n_chk = 0;
   int n_bad = 0;
   bit tog = 1'b0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   frame_sync_gen u0 (
      .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .frame_start(frame_start),
      .mode(mode), .sync_len(sync_len), .word_len(word_len), .word_cnt(word_cnt),
      .msb_first(msb_first), .sync_data_en(sync_data_en), .edge_sel(edge_sel),
      .sync_word(sync_word), .ser_in(ser_in), .sync_pin_in(sync_pin_in),
      .sync_out(sync_out), .sync_oe(sync_oe), .active(active), .bit_idx(bit_idx),
      .sync_slot(sync_slot), .sync_tx_bit(sync_tx_bit), .sync_cap(sync_cap),
      .sync_seen(sync_seen)
   );

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic void exp_line(input logic [2:0] m, input bit slot, input bit dat,
                                    output int o, output int oe);
      oe = 1;
      case (m)
         3'd1: o = !slot;
         3'd2: o = slot;
         3'd3: o = !dat;
         3'd4: o = dat;
         3'd5: o = tog;
         default: begin o = 0; oe = 0; end
      endcase
   endfunction

   task automatic launch();
      @(posedge clk); #1 frame_start = 1'b1;
      @(posedge clk); #1 frame_start = 1'b0;
      tog = !tog;
   endtask

   // Whole-frame comparison covering R2, R3, R4, R5, R6, R7
   task automatic run_frame(input logic [2:0] m, input int sl, input int wl, input int wc,
                            input bit msb, input string tag);
      int o, oe;
      bit pulse;
      mode = m; sync_len = 4'(sl); word_len = 5'(wl); word_cnt = 4'(wc);
      msb_first = msb; sync_data_en = 1'b0;
      pulse = (m == 3'd1 || m == 3'd2);
      @(negedge clk);
      exp_line(m, 0, 0, o, oe);
      chk({tag, " idle line"}, sync_out, o);
      chk({tag, " idle oe"}, sync_oe, oe);
      launch();
      if (pulse) begin
         for (int i = 0; i <= sl; i++) begin
            @(negedge clk);
            exp_line(m, 1, 0, o, oe);
            chk({tag, " R3 pulse line"}, sync_out, o);
            chk({tag, " R6 inactive in slot"}, active, 0);
            chk({tag, " R10 slot off"}, sync_slot, 0);
         end
      end
      for (int n = 0; n < (wl + 1) * (wc + 1); n++) begin
         @(negedge clk);
         exp_line(m, 0, 1, o, oe);
         chk({tag, " R6 active"}, active, 1);
         chk({tag, " R7 index"}, bit_idx, msb ? wl - (n % (wl + 1)) : n % (wl + 1));
         chk({tag, " line in data"}, sync_out, o);
         chk({tag, " oe in data"}, sync_oe, oe);
      end
      @(negedge clk);
      exp_line(m, 0, 0, o, oe);
      chk({tag, " R6 end"}, active, 0);
      chk({tag, " line after"}, sync_out, o);
   endtask

   task automatic t_reset();
      @(negedge clk);
      chk("R1 active", active, 0);
      chk("R1 bit_idx", bit_idx, 0);
      chk("R1 slot", sync_slot, 0);
      chk("R1 cap", sync_cap, 0);
      chk("R1 seen", sync_seen, 0);
      mode = 3'd5;
      @(negedge clk);
      chk("R1 toggle level", sync_out, 0);
      mode = 3'd0;
   endtask

   task automatic t_modes();
      run_frame(3'd2, 2, 3, 1, 1'b0, "R3 pos");
      run_frame(3'd1, 0, 7, 0, 1'b1, "R3 neg");
      run_frame(3'd3, 0, 2, 2, 1'b0, "R4 low");
      run_frame(3'd4, 5, 1, 3, 1'b1, "R4 high");
      run_frame(3'd5, 0, 2, 0, 1'b0, "R5 toggle a");
      run_frame(3'd5, 0, 0, 1, 1'b0, "R5 toggle b");
      run_frame(3'd0, 0, 1, 1, 1'b0, "R2 mode0");
      run_frame(3'd6, 3, 2, 0, 1'b1, "R2 mode6");
      run_frame(3'd7, 0, 0, 2, 1'b0, "R2 mode7");
   endtask

   task automatic t_ignore_midframe();
      mode = 3'd5; word_len = 5'd1; word_cnt = 4'd1; msb_first = 1'b0;
      launch();
      @(negedge clk); chk("R8 idx0", bit_idx, 0);
      frame_start = 1'b1;
      @(negedge clk); frame_start = 1'b0;
      chk("R8 idx1", bit_idx, 1);
      @(negedge clk); chk("R8 idx2", bit_idx, 0);
      @(negedge clk); chk("R8 still active", active, 1);
      @(negedge clk); chk("R8 frame ended", active, 0);
      chk("R8 toggle unchanged", sync_out, tog);
   endtask

   task automatic t_back_to_back();
      mode = 3'd0; word_len = 5'd1; word_cnt = 4'd0;
      launch();
      @(negedge clk); chk("R9 first idx", bit_idx, 0);
      @(negedge clk); chk("R9 last idx", bit_idx, 1);
      frame_start = 1'b1;
      @(negedge clk); frame_start = 1'b0; tog = !tog;
      chk("R9 no gap", active, 1);
      chk("R9 restart idx", bit_idx, 0);
      @(negedge clk); chk("R9 second idx", bit_idx, 1);
      @(negedge clk); chk("R9 end", active, 0);
   endtask

   task automatic t_stall();
      mode = 3'd0; word_len = 5'd3; word_cnt = 4'd0;
      launch();
      @(negedge clk); chk("R13 idx0", bit_idx, 0);
      @(negedge clk); chk("R13 idx1", bit_idx, 1);
      bit_en = 1'b0; frame_start = 1'b1;
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         chk("R13 held idx", bit_idx, 1);
         chk("R13 held active", active, 1);
      end
      frame_start = 1'b0; bit_en = 1'b1;
      @(negedge clk); chk("R13 resumes", bit_idx, 2);
      @(negedge clk); @(negedge clk); chk("R13 end", active, 0);
   endtask

   task automatic t_slot_data(input bit msb);
      logic [3:0] pat;
      int p;
      pat = 4'b0110;
      mode = 3'd2; sync_len = 4'd3; word_len = 5'd1; word_cnt = 4'd0;
      msb_first = msb; sync_data_en = 1'b1; sync_word = 16'h000B;
      launch();
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         p = msb ? 3 - i : i;
         chk("R10 slot flag", sync_slot, 1);
         chk("R10 tx bit", sync_tx_bit, sync_word[p]);
         ser_in = pat[p];
      end
      @(negedge clk);
      chk("R10 slot over", sync_slot, 0);
      chk("R10 tx quiet", sync_tx_bit, 0);
      chk("R11 captured", sync_cap, 16'h0006);
      ser_in = 1'b1;
      @(negedge clk); @(negedge clk);
      chk("R11 held after frame", sync_cap, 16'h0006);
      sync_data_en = 1'b0;
   endtask

   task automatic t_edges();
      mode = 3'd0; edge_sel = 1'b0; sync_pin_in = 1'b0;
      @(negedge clk); @(negedge clk);
      sync_pin_in = 1'b1;
      @(negedge clk); chk("R12 rise seen", sync_seen, 1);
      @(negedge clk); chk("R12 one cycle", sync_seen, 0);
      sync_pin_in = 1'b0;
      @(negedge clk); chk("R12 fall ignored", sync_seen, 0);
      edge_sel = 1'b1;
      sync_pin_in = 1'b1;
      @(negedge clk); chk("R12 rise ignored", sync_seen, 0);
      sync_pin_in = 1'b0;
      @(negedge clk); chk("R12 fall seen", sync_seen, 1);
      @(negedge clk); chk("R12 pulse ends", sync_seen, 0);
   endtask

   initial begin
      #(4 * 20000);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      t_reset();
      t_modes();
      t_ignore_midframe();
      t_back_to_back();
      t_stall();
      t_slot_data(1'b0);
      t_slot_data(1'b1);
      t_edges();
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule